// File: doc/BRIEF.md
# Gated Fractional Clock-Enable Divider

This block turns a fast reference clock into a slower stream of single-cycle enable pulses. The average pulse rate is the reference rate times 18 divided by a programmable divide value N. N may run from 18 to 35, so the output spans the full reference rate down to a little over half of it. A phase accumulator adds 18 on every reference cycle. Each time the sum reaches N, it takes N back off and emits one pulse.

Software writes a new N through a write strobe. The value is held as pending and moves into the divider only when the accumulator wraps. A read-only stable bit inverts at that moment, so software reads the bit, writes N, and waits for the bit to flip. A gate bit stops the pulse stream and freezes the accumulator to save power. Entering or leaving the gated state never flips the stable bit.

Top module: `fracdiv_gated`

## Requirements
- R1: While reset is held and directly after it, `clk_en_o` is 0, `gate_o` is 0, `stable_o` is 0 and `div_active_o` is 18.
- R2: While ungated with a fixed N, the number of pulses on `clk_en_o` over W reference cycles is within one of W*18/N.
- R3: While `gate_o` is 1, `clk_en_o` stays 0 and the accumulator phase is held. The first reference cycle after the gate is set may still carry one pulse that was already decided.
- R4: Each write of N causes exactly one inversion of `stable_o`. The inversion happens in the same cycle that `div_active_o` takes the new value, including when the written value equals the current one.
- R5: Setting or clearing the gate bit, with no divide write outstanding, never inverts `stable_o`.
- R6: A written value below 18 is used as 18, and a written value above 35 is used as 35. `div_active_o` always lies in 18..35.
- R7: A written N becomes active only at an accumulator wrap. A value written while gated stays pending: `div_active_o` and `stable_o` do not change until the gate is cleared. It is then applied within two reference cycles.
- R8: With N = 18, `clk_en_o` is 1 on every reference cycle.
- R9: `div_active_o` reports the divide value the accumulator is currently using.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_wr_en | input | 1 | Strobe: capture `div_wr_val` as the pending divide value |
| div_wr_val | input | DIV_W | Requested divide value N (clamped to 18..35) |
| gate_wr_en | input | 1 | Strobe: load `gate_wr_val` into the gate bit |
| gate_wr_val | input | 1 | New gate bit: 1 stops the output, 0 lets it run |
| clk_en_o | output | 1 | Single-cycle enable pulse train |
| gate_o | output | 1 | Current gate bit |
| div_active_o | output | DIV_W | Divide value in use |
| stable_o | output | 1 | Read-only bit that inverts when a new N takes effect |

## Verification
The bench steps through a set of divide values, including out-of-range ones, and measures the pulse count over a window. A wrong clamp or a wrong accumulator compare would show up as a count far from W*18/N, or as a readback outside 18..35. It rewrites the value already in use and expects one flip of `stable_o`. A design that compared the old and new values before loading would show no flip and leave software waiting forever. It writes N while gated and then toggles the gate with nothing pending. A design that loaded during the gated state, or tied the stable bit to gate edges, would flip it at the wrong moment or too often.

// File: rtl/fracdiv_pkg.sv
package fracdiv_pkg;
    // Fixed numerator added per reference cycle
    localparam int FD_STEP    = 18;
    // Legal divide range
    localparam int FD_DIV_MIN = 18;
    localparam int FD_DIV_MAX = 35;
    // Width of the divide field
    localparam int FD_DIV_W   = 6;
endpackage

// File: rtl/fracdiv_clamp.sv
module fracdiv_clamp #(
    parameter int W   = 6,
    parameter int MIN = 18,
    parameter int MAX = 35
) (
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] lim_o
);
    localparam logic [W-1:0] LO = W'(MIN);
    localparam logic [W-1:0] HI = W'(MAX);

    always_comb begin
        if (raw_i < LO) begin
            lim_o = LO;
        end else if (raw_i > HI) begin
            lim_o = HI;
        end else begin
            lim_o = raw_i;
        end
    end
endmodule

// File: rtl/fracdiv_accum.sv
module fracdiv_accum #(
    parameter int STEP  = 18,
    parameter int DIV_W = 6,
    parameter int ACC_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             wrap_o,
    output logic             pulse_o
);
    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             pulse;
    } acc_st_t;

    acc_st_t st_d, st_q;
    logic [ACC_W-1:0] sum;
    logic [ACC_W-1:0] div_ext;
    logic             wrap;

    always_comb begin
        div_ext = ACC_W'(div_i);
        sum     = st_q.acc + ACC_W'(STEP);
        wrap    = run_i && (sum >= div_ext);
        st_d    = st_q;
        if (run_i) begin
            st_d.acc = wrap ? (sum - div_ext) : sum;
        end
        st_d.pulse = wrap;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wrap_o  = wrap;
    assign pulse_o = st_q.pulse;

    // Phase must stay below the active divide value
    p_acc_below_div_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.acc < div_ext);

    // Gated cycle yields no pulse next cycle
    p_gate_no_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !pulse_o);

    // Gated cycle keeps the phase
    p_gate_freeze_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> $stable(st_q.acc));
endmodule

// File: rtl/fracdiv_ctrl.sv
module fracdiv_ctrl #(
    parameter int DIV_W = 6,
    parameter int MIN   = 18,
    parameter int MAX   = 35
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [DIV_W-1:0] wr_val_i,
    input  logic             gate_wr_en_i,
    input  logic             gate_wr_val_i,
    input  logic             wrap_i,
    output logic [DIV_W-1:0] div_o,
    output logic             gate_o,
    output logic             stable_o
);
    localparam logic [DIV_W-1:0] RST_DIV = DIV_W'(MIN);
    localparam logic [DIV_W-1:0] LO      = DIV_W'(MIN);
    localparam logic [DIV_W-1:0] HI      = DIV_W'(MAX);

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [DIV_W-1:0] pend;
        logic             pend_vld;
        logic             gate;
        logic             stable;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // Load pending value only at a wrap
        if (wrap_i && st_q.pend_vld) begin
            st_d.div      = st_q.pend;
            st_d.stable   = ~st_q.stable;
            st_d.pend_vld = 1'b0;
        end
        // A fresh write always lands in the pending slot
        if (wr_en_i) begin
            st_d.pend     = wr_val_i;
            st_d.pend_vld = 1'b1;
        end
        if (gate_wr_en_i) begin
            st_d.gate = gate_wr_val_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.div      <= RST_DIV;
            st_q.pend     <= RST_DIV;
            st_q.pend_vld <= 1'b0;
            st_q.gate     <= 1'b0;
            st_q.stable   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign div_o    = st_q.div;
    assign gate_o   = st_q.gate;
    assign stable_o = st_q.stable;

    // Stable bit flips only on a load of a pending value
    p_stable_on_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.stable) |-> $past(wrap_i && st_q.pend_vld));

    // Gated state leaves stable bit and divide value alone
    p_gate_no_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.gate |=> $stable(st_q.stable) && $stable(st_q.div));

    // Active and pending values stay inside the legal range
    p_div_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.div >= LO) && (st_q.div <= HI));
    p_pend_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pend_vld |-> (st_q.pend >= LO) && (st_q.pend <= HI));

    // Divide value changes only at a wrap
    p_load_at_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.div) |-> $past(wrap_i));
endmodule

// File: rtl/fracdiv_gated.sv
module fracdiv_gated
    import fracdiv_pkg::*;
#(
    parameter int STEP    = FD_STEP,
    parameter int DIV_MIN = FD_DIV_MIN,
    parameter int DIV_MAX = FD_DIV_MAX,
    parameter int DIV_W   = FD_DIV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             div_wr_en,
    input  logic [DIV_W-1:0] div_wr_val,
    input  logic             gate_wr_en,
    input  logic             gate_wr_val,
    output logic             clk_en_o,
    output logic             gate_o,
    output logic [DIV_W-1:0] div_active_o,
    output logic             stable_o
);
    // Accumulator must hold up to DIV_MAX-1+STEP
    localparam int ACC_RAW = $clog2(DIV_MAX + STEP);
    localparam int ACC_W   = (ACC_RAW > DIV_W) ? ACC_RAW : DIV_W;

    logic [DIV_W-1:0] wr_lim;
    logic [DIV_W-1:0] div_cur;
    logic             gate_cur;
    logic             wrap;

    fracdiv_clamp #(
        .W   (DIV_W),
        .MIN (DIV_MIN),
        .MAX (DIV_MAX)
    ) i_clamp (
        .raw_i (div_wr_val),
        .lim_o (wr_lim)
    );

    fracdiv_ctrl #(
        .DIV_W (DIV_W),
        .MIN   (DIV_MIN),
        .MAX   (DIV_MAX)
    ) i_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en_i       (div_wr_en),
        .wr_val_i      (wr_lim),
        .gate_wr_en_i  (gate_wr_en),
        .gate_wr_val_i (gate_wr_val),
        .wrap_i        (wrap),
        .div_o         (div_cur),
        .gate_o        (gate_cur),
        .stable_o      (stable_o)
    );

    fracdiv_accum #(
        .STEP  (STEP),
        .DIV_W (DIV_W),
        .ACC_W (ACC_W)
    ) i_accum (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (~gate_cur),
        .div_i   (div_cur),
        .wrap_o  (wrap),
        .pulse_o (clk_en_o)
    );

    assign gate_o       = gate_cur;
    assign div_active_o = div_cur;

    // Full rate at the smallest divide value
    p_full_rate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_cur && div_cur == DIV_W'(DIV_MIN)) |=> clk_en_o);
endmodule

// File: tb/test_fracdiv_gated.sv
module test_fracdiv_gated;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 360;
    localparam int NV         = 10;
    // {written value, expected active value}
    localparam int VEC [NV][2] = '{
        '{24, 24}, '{20, 20}, '{35, 35}, '{27, 27}, '{18, 18},
        '{3, 18},  '{50, 35}, '{63, 35}, '{22, 22}, '{0, 18}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       div_wr_en = 1'b0;
    logic [5:0] div_wr_val = '0;
    logic       gate_wr_en = 1'b0;
    logic       gate_wr_val = 1'b0;
    logic       clk_en_o, gate_o, stable_o;
    logic [5:0] div_active_o;

    int  checks = 0;
    int  fails = 0;
    int  togg_cnt = 0;
    int  pulse_cnt = 0;
    logic stable_prev = 1'b0;
    bit  done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fracdiv_gated i_fracdiv_gated (
        .clk          (clk),
        .rst_n        (rst_n),
        .div_wr_en    (div_wr_en),
        .div_wr_val   (div_wr_val),
        .gate_wr_en   (gate_wr_en),
        .gate_wr_val  (gate_wr_val),
        .clk_en_o     (clk_en_o),
        .gate_o       (gate_o),
        .div_active_o (div_active_o),
        .stable_o     (stable_o)
    );

    // Observe outputs half a period after each edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (stable_o !== stable_prev) togg_cnt++;
            if (clk_en_o === 1'b1) pulse_cnt++;
        end
        stable_prev = stable_o;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_counts();
        @(posedge clk);
        togg_cnt  = 0;
        pulse_cnt = 0;
    endtask

    task automatic write_div(input int v);
        @(negedge clk);
        div_wr_en  = 1'b1;
        div_wr_val = 6'(v);
        @(negedge clk);
        div_wr_en  = 1'b0;
    endtask

    task automatic write_gate(input bit g);
        @(negedge clk);
        gate_wr_en  = 1'b1;
        gate_wr_val = g;
        @(negedge clk);
        gate_wr_en  = 1'b0;
    endtask

    task automatic wait_toggle(input int limit);
        for (int k = 0; k < limit && togg_cnt == 0; k++) @(posedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        int ideal, diff, prev_div;
        // R1: reset state
        repeat (3) @(negedge clk);
        check(clk_en_o == 1'b0, "R1", "pulse in reset", int'(clk_en_o), 0);
        check(gate_o == 1'b0, "R1", "gate in reset", int'(gate_o), 0);
        check(stable_o == 1'b0, "R1", "stable in reset", int'(stable_o), 0);
        check(div_active_o == 6'd18, "R1", "div in reset", int'(div_active_o), 18);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(stable_o == 1'b0 && div_active_o == 6'd18, "R1", "state after reset",
              int'(div_active_o), 18);

        // R8: full rate at N = 18
        clear_counts();
        repeat (40) @(posedge clk);
        check(pulse_cnt == 40, "R8", "pulses at N=18", pulse_cnt, 40);

        // Table walk: R2 rate, R4 one flip, R6 clamp, R9 readback
        for (int i = 0; i < NV; i++) begin
            clear_counts();
            write_div(VEC[i][0]);
            wait_toggle(80);
            repeat (3) @(posedge clk);
            check(togg_cnt == 1, "R4", "stable flips per write", togg_cnt, 1);
            check(int'(div_active_o) == VEC[i][1], "R6", "clamped active value",
                  int'(div_active_o), VEC[i][1]);
            clear_counts();
            repeat (W) @(posedge clk);
            ideal = (W * 18) / VEC[i][1];
            diff  = pulse_cnt - ideal;
            check(diff >= -1 && diff <= 1, "R2", "pulse count in window", pulse_cnt, ideal);
            check(togg_cnt == 0, "R9", "no flip while value in use", togg_cnt, 0);
        end

        // R3/R5: entering the gated state
        clear_counts();
        write_gate(1'b1);
        repeat (2) @(posedge clk);
        check(gate_o == 1'b1, "R3", "gate readback", int'(gate_o), 1);
        check(togg_cnt == 0, "R5", "no flip on gate set", togg_cnt, 0);
        prev_div = int'(div_active_o);
        clear_counts();
        // R7: write while gated stays pending
        write_div(30);
        repeat (40) @(posedge clk);
        check(pulse_cnt == 0, "R3", "pulses while gated", pulse_cnt, 0);
        check(togg_cnt == 0, "R7", "no flip while gated", togg_cnt, 0);
        check(int'(div_active_o) == prev_div, "R7", "div held while gated",
              int'(div_active_o), prev_div);
        // Ungate: pending value applied within two cycles
        clear_counts();
        write_gate(1'b0);
        repeat (3) @(posedge clk);
        check(togg_cnt == 1, "R7", "flip after ungating", togg_cnt, 1);
        check(div_active_o == 6'd30, "R7", "pending applied", int'(div_active_o), 30);

        // R5: gate set and clear with nothing pending
        clear_counts();
        write_gate(1'b1);
        repeat (5) @(posedge clk);
        write_gate(1'b0);
        repeat (40) @(posedge clk);
        check(togg_cnt == 0, "R5", "no flip on gate cycle", togg_cnt, 0);
        check(pulse_cnt > 0, "R3", "output resumes after ungate", pulse_cnt, 1);

        finish_run();
    end
endmodule